// File: doc/BRIEF.md
# Slot-Selected Command Register Slave

This block is the module-side end of a slot-addressed crate backplane. A module plugged into a slot does not compare addresses. The backplane raises a dedicated select line for that slot. Together with the select, the controller presents a 4-bit subaddress, a 5-bit function code and a write data word.

A command is carried out when a strobe pulse arrives while the select line is high. Two function codes are recognised. The read code puts the chosen internal register on the read bus. The write code loads the write word into the chosen register on the clock edge that ends the strobe cycle.

Sixteen internal registers are indexed by subaddress. For each command it accepts, the slave raises a response flag in the same cycle. Every other function code, or a strobe without select, is left alone: it gets no response, produces no data and changes no register.

Top module: `slot_cmd_slave`

## Requirements
- R1: After reset is released, all 16 registers read back as zero.
- R2: While `stn_sel_i` is low, the block ignores every command: `resp_o` is 0, `rdata_o` is 0 and no register changes, whatever the strobe, function, subaddress or data.
- R3: While `strobe_i` is low, the block likewise ignores the command: no response, zero read data, no register change.
- R4: Function code 0 (5'b00000) with select and strobe high drives `rdata_o` with the register chosen by `subaddr_i` and raises `resp_o`, both combinationally in the same cycle.
- R5: Function code 16 (5'b10000) with select and strobe high raises `resp_o` in the same cycle. It loads `wdata_i` into the register chosen by `subaddr_i` at the rising clock edge of that cycle. `rdata_o` stays 0 during the write.
- R6: Any function code other than 0 and 16 gets no response, keeps `rdata_o` at 0 and changes no register.
- R7: A write touches only the register chosen by its subaddress. The other 15 registers keep their values.
- R8: `rdata_o` is 0 in every cycle that is not an accepted read command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stn_sel_i | input | 1 | Dedicated slot select line |
| strobe_i | input | 1 | Command strobe |
| subaddr_i | input | 4 | Register index |
| func_i | input | 5 | Function code |
| wdata_i | input | DATA_W (16) | Write data bus |
| rdata_o | output | DATA_W (16) | Read data bus, zero unless an accepted read is in progress |
| resp_o | output | 1 | Command accepted |

## Verification
Some properties are checked on every cycle:
- the decoder never asks for a read and a write at once;
- a register moves only after a write hit on its own index, and then holds exactly the data captured;
- read data is non-zero only during an accepted read.

Other behaviour can only be shown by the bench's sweeps. These cover the full 32-code function space, writes to every subaddress with distinct patterns, and commands with select or strobe missing. Each sweep is followed by a read-back of all registers, which proves that the ignored commands left no trace.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
  localparam int FUNC_W = 5;
  localparam int SUB_W  = 4;
  localparam int NREG   = 1 << SUB_W;

  localparam logic [FUNC_W-1:0] FN_READ  = 5'd0;
  localparam logic [FUNC_W-1:0] FN_WRITE = 5'd16;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE
  } cmd_kind_e;
endpackage

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode
  import slot_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stn_sel_i,
  input  logic              strobe_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              resp_o
);
  cmd_kind_e kind;

  always_comb begin
    kind = CMD_NONE;
    if (stn_sel_i && strobe_i) begin
      unique case (func_i)
        FN_READ:  kind = CMD_READ;
        FN_WRITE: kind = CMD_WRITE;
        default:  kind = CMD_NONE;
      endcase
    end
  end

  assign rd_en_o = (kind == CMD_READ);
  assign wr_en_o = (kind == CMD_WRITE);
  assign resp_o  = (kind != CMD_NONE);

  // R4 R5
  excl_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));

  // R2 R3
  no_sel_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |-> (stn_sel_i && strobe_i));
endmodule

// File: rtl/slot_reg_bank.sv
module slot_reg_bank
  import slot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SUB_W-1:0]             sub_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
  logic [NREG-1:0] wr_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_hit[i] = wr_en_i && (sub_i == SUB_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_o[i] <= '0;
      else if (wr_hit[i]) regs_o[i] <= wdata_i;
    end

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit[i] |=> $stable(regs_o[i]));

    // R5
    load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[i] |=> (regs_o[i] == $past(wdata_i)));
  end
endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
  import slot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         rd_en_i,
  input  logic [SUB_W-1:0]             sub_i,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_i,
  output logic [DATA_W-1:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) rdata_o = regs_i[sub_i];
  end
endmodule

// File: rtl/slot_cmd_slave.sv
module slot_cmd_slave
  import slot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stn_sel_i,
  input  logic              strobe_i,
  input  logic [SUB_W-1:0]  subaddr_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              resp_o
);
  logic rd_en, wr_en;
  logic [NREG-1:0][DATA_W-1:0] regs;

  slot_cmd_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stn_sel_i (stn_sel_i),
    .strobe_i  (strobe_i),
    .func_i    (func_i),
    .rd_en_o   (rd_en),
    .wr_en_o   (wr_en),
    .resp_o    (resp_o)
  );

  slot_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .sub_i   (subaddr_i),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  slot_read_mux #(.DATA_W(DATA_W)) u_mux (
    .rd_en_i (rd_en),
    .sub_i   (subaddr_i),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  // R8
  rdata_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != '0) |-> rd_en);

  // R6
  unknown_fn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i != FN_READ && func_i != FN_WRITE) |-> !resp_o);
endmodule

// File: tb/slot_cmd_slave_test.sv
module slot_cmd_slave_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel = 1'b0, stb = 1'b0;
  logic [3:0]    sub = '0;
  logic [4:0]    fn = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic          resp;

  logic [DW-1:0] model [16];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_cmd_slave #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .stn_sel_i(sel), .strobe_i(stb),
    .subaddr_i(sub), .func_i(fn), .wdata_i(wd), .rdata_o(rdata), .resp_o(resp)
  );

  task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one command cycle; response/data sampled mid-cycle
  task automatic cmd(string req, logic s, logic t, logic [4:0] f,
                     logic [3:0] a, logic [DW-1:0] d);
    bit acc;
    @(negedge clk);
    sel = s; stb = t; fn = f; sub = a; wd = d;
    #1;
    acc = s && t && (f == 5'd0 || f == 5'd16);
    chk(req, {resp, rdata},
        {acc, (s && t && f == 5'd0) ? model[a] : {DW{1'b0}}});
    @(posedge clk);
    if (s && t && f == 5'd16) model[a] = d;
    @(negedge clk);
    sel = 0; stb = 0; fn = 0; wd = 0;
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 16; i++) cmd(req, 1, 1, 5'd0, 4'(i), '0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    read_all("R1");

    // R5 R7: distinct pattern per register
    for (int i = 0; i < 16; i++)
      cmd("R5", 1, 1, 5'd16, 4'(i), 16'(i * 16'h1111 ^ 16'h0F0F));
    read_all("R4");

    // R7: single write moves only its target
    cmd("R7", 1, 1, 5'd16, 4'd9, 16'hBEEF);
    read_all("R7");

    // R6: all other function codes, with data that would change state
    for (int f = 0; f < 32; f++)
      if (f != 0 && f != 16) cmd("R6", 1, 1, 5'(f), 4'(f % 16), 16'hDEAD);
    read_all("R6");

    // R2: no select, every function
    for (int f = 0; f < 32; f++) cmd("R2", 0, 1, 5'(f), 4'(f % 16), 16'h5A5A);
    // R3: no strobe
    for (int f = 0; f < 32; f++) cmd("R3", 1, 0, 5'(f), 4'(f % 16), 16'hA5A5);
    read_all("R8");

    // boundary data values on extreme subaddresses
    cmd("R5", 1, 1, 5'd16, 4'd0, 16'hFFFF);
    cmd("R5", 1, 1, 5'd16, 4'd15, 16'h0000);
    read_all("R4");

    // R8: idle cycle reads zero
    @(negedge clk); #1;
    chk("R8", {resp, rdata}, '0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule